// File: doc/BRIEF.md
# Key-Protected Deep-Sleep Entry Controller

This block decides whether a chip may drop into deep sleep. Software asks for sleep through a small word-addressed register bus. It writes a pass key and then an enter key, and both must arrive as consecutive bus writes. Before the block raises its sleep request, it checks several gates: the mode pin (low means debug), a sticky wake-pending flag, and the drop status of two supply monitors. Each monitor has its own policy bit. When the policy bit is 0, entry needs that supply to have dropped. When it is 1, the monitor is ignored.

Once the request is up, it falls again on a wake event. It also falls if a supply whose policy is 0 comes back. Either way the block sets the wake-pending flag, and software clears that flag by writing a one to it. A refused entry leaves no trace: the request simply stays low, and software sees that it is still running.

The block also keeps one sticky flag per reset cause. A pulse from the reset logic sets the flag, and writing a one clears it. The mode pin and both supply monitors are asynchronous. Each one passes through a two-flop synchroniser before any gate uses it.

Top module: `dslp_entry_ctrl`

## Requirements
- R1: After reset, `sleep_req` is 0, the wake-pending flag is 0, both policy bits are 0 and all reset-cause flags are 0.
- R2: A write of 0xAA5555AA to the pass register (word 0), followed by a write of 0x55AAAA55 to the enter register (word 1) as the very next bus write, raises `sleep_req` on the clock edge that takes the second write, provided every gate is open.
- R3: Entry is refused in four cases: a different write comes between the two keys, either key has a wrong value, the keys come in reverse order, or the enter key comes with no pass key before it.
- R4: While the synchronised mode pin is 0, entry is refused. The synchronised pin reads back at bit 0 of the status register (word 3).
- R5: While the wake-pending flag (bit 1 of the enter register) is 1, entry is refused.
- R6: Bit 0 of the policy register (word 2) sets the DC-in monitor policy. At 0, entry is refused unless the synchronised DC-in drop input is 1. At 1, the DC-in monitor is ignored. The synchronised value reads at status bit 1.
- R7: Bit 1 of the policy register sets the VDD monitor policy in the same way, using the synchronised VDD-low input. That value reads at status bit 2.
- R8: A `wake_evt` pulse while `sleep_req` is 1 clears `sleep_req` on that edge and sets the wake-pending flag. Writing 1 to enter-register bit 1 clears the flag. If a set and a clear arrive on the same edge, the set wins. A `wake_evt` while awake has no effect.
- R9: While asleep, a supply whose policy bit is 0 and whose synchronised drop status returns to 0 ends sleep exactly as a wake event does.
- R10: Reset-cause flags sit at status bits 4 (external), 5 (power-on) and 6 (deep power-on). A pulse on the matching `rst_cause` bit sets a flag. Writing 1 to a bit clears it. If a set and a clear arrive on the same edge, the set wins.
- R11: A change on `mode_pin`, `dcin_drop` or `vdd_low` becomes visible at the status register, and to the gates, after exactly two clock edges.
- R12: The pass register reads 0. The policy register reads back the last value written to its two bits. Unused bits and unused words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| addr | input | ADDR_W | Word address for writes and reads |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| mode_pin | input | 1 | Mode pin, 0 = debug, asynchronous |
| dcin_drop | input | 1 | DC-in supply has dropped, asynchronous |
| vdd_low | input | 1 | VDD is below its threshold, asynchronous |
| wake_evt | input | 1 | Synchronous wake event pulse |
| rst_cause | input | N_RST | Synchronous reset-cause pulses (external, power-on, deep power-on) |
| sleep_req | output | 1 | Deep-sleep request |

## Verification
The bench checks the unlock corner cases, because a design that remembered the pass key across other writes, or that accepted the keys in reverse, would sleep when it should not. It checks each veto alone and then each policy override. A gate wired to the raw input rather than the synchronised one would act one or two cycles early, and the synchroniser latency is checked at the exact edge. It also checks the same-edge set-and-clear race on the wake-pending flag and the reset flags, where a design with the wrong priority would lose a wake or a reset cause. Finally, it checks supply-return wake-up, which a design that honoured only `wake_evt` would miss, leaving the request stuck high.

// File: rtl/dslp_pkg.sv
package dslp_pkg;
   // register word indices
   localparam int REG_PASS   = 0;
   localparam int REG_ENTER  = 1;
   localparam int REG_POLICY = 2;
   localparam int REG_STATUS = 3;

   // bit positions
   localparam int PEND_BIT   = 1;
   localparam int POL_DC     = 0;
   localparam int POL_VDD    = 1;
   localparam int ST_MODE    = 0;
   localparam int ST_DC      = 1;
   localparam int ST_VDD     = 2;
   localparam int ST_RST_LSB = 4;

   // synchroniser lane order
   localparam int LANE_MODE  = 0;
   localparam int LANE_DC    = 1;
   localparam int LANE_VDD   = 2;
   localparam int N_LANES    = 3;

   localparam logic [31:0] KEY_PASS_DEF  = 32'hAA55_55AA;
   localparam logic [31:0] KEY_ENTER_DEF = 32'h55AA_AA55;
endpackage

// File: rtl/dslp_sync.sv
module dslp_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dslp_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end
endmodule

// File: rtl/dslp_w1c.sv
module dslp_w1c #(
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   if (N < 1) begin : g_bad_n
      $error("dslp_w1c: N must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      f_q <= 1'b0;
         else if (set[i]) f_q <= 1'b1;
         else if (clr[i]) f_q <= 1'b0;
      end
      assign q[i] = f_q;
   end
endmodule

// File: rtl/dslp_unlock.sv
module dslp_unlock #(
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] PASS_KEY  = '0,
   parameter logic [DATA_W-1:0] ENTER_KEY = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              sel_pass,
   input  logic              sel_enter,
   input  logic [DATA_W-1:0] wdata,
   output logic              armed,
   output logic              enter_ok
);
   if (PASS_KEY == ENTER_KEY) begin : g_bad_keys
      $error("dslp_unlock: the two keys must differ");
   end

   logic armed_q;

   // every write re-evaluates the arm state, so only an adjacent pair unlocks
   always_ff @(posedge clk) begin
      if (!rst_n)     armed_q <= 1'b0;
      else if (wr_en) armed_q <= sel_pass && (wdata == PASS_KEY);
   end

   assign armed    = armed_q;
   assign enter_ok = wr_en && sel_enter && armed_q && (wdata == ENTER_KEY);
endmodule

// File: rtl/dslp_entry_ctrl.sv
module dslp_entry_ctrl
   import dslp_pkg::*;
#(
   parameter int                ADDR_W      = 2,
   parameter int                DATA_W      = 32,
   parameter int                SYNC_STAGES = 2,
   parameter int                N_RST       = 3,
   parameter logic [DATA_W-1:0] PASS_KEY    = DATA_W'(KEY_PASS_DEF),
   parameter logic [DATA_W-1:0] ENTER_KEY   = DATA_W'(KEY_ENTER_DEF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              mode_pin,
   input  logic              dcin_drop,
   input  logic              vdd_low,
   input  logic              wake_evt,
   input  logic [N_RST-1:0]  rst_cause,
   output logic              sleep_req
);
   localparam int ST_TOP = ST_RST_LSB + N_RST;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("dslp_entry_ctrl: ADDR_W must cover four registers");
   end
   if (DATA_W < ST_TOP) begin : g_bad_data
      $error("dslp_entry_ctrl: DATA_W too narrow for the status layout");
   end
   if (ENTER_KEY[PEND_BIT] != 1'b0) begin : g_bad_key
      $error("dslp_entry_ctrl: enter key would clear the wake-pending flag");
   end

   // decode
   logic sel_pass, sel_enter, sel_policy, sel_status;
   assign sel_pass   = (addr == ADDR_W'(REG_PASS));
   assign sel_enter  = (addr == ADDR_W'(REG_ENTER));
   assign sel_policy = (addr == ADDR_W'(REG_POLICY));
   assign sel_status = (addr == ADDR_W'(REG_STATUS));

   // detector synchronisers
   logic [N_LANES-1:0] raw_in, sync_out;
   logic               mode_s, dc_s, vdd_s;
   assign raw_in[LANE_MODE] = mode_pin;
   assign raw_in[LANE_DC]   = dcin_drop;
   assign raw_in[LANE_VDD]  = vdd_low;

   dslp_sync #(.W(N_LANES), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d (raw_in),
      .q (sync_out)
   );
   assign mode_s = sync_out[LANE_MODE];
   assign dc_s   = sync_out[LANE_DC];
   assign vdd_s  = sync_out[LANE_VDD];

   // key sequencing
   logic armed, enter_ok;
   dslp_unlock #(.DATA_W(DATA_W), .PASS_KEY(PASS_KEY), .ENTER_KEY(ENTER_KEY)) u_unlock (
      .clk (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .sel_pass (sel_pass),
      .sel_enter (sel_enter),
      .wdata (wdata),
      .armed (armed),
      .enter_ok (enter_ok)
   );

   // policy register
   logic [1:0] pol_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                  pol_q <= '0;
      else if (wr_en && sel_policy) pol_q <= {wdata[POL_VDD], wdata[POL_DC]};
   end

   // gating and wake
   logic sleep_q, pend_q, gate_ok, supply_back, wake;
   assign gate_ok = mode_s && !pend_q
                    && (pol_q[POL_DC] || dc_s)
                    && (pol_q[POL_VDD] || vdd_s);
   assign supply_back = (!pol_q[POL_DC] && !dc_s) || (!pol_q[POL_VDD] && !vdd_s);
   assign wake = sleep_q && (wake_evt || supply_back);

   always_ff @(posedge clk) begin
      if (!rst_n)                   sleep_q <= 1'b0;
      else if (wake)                sleep_q <= 1'b0;
      else if (enter_ok && gate_ok) sleep_q <= 1'b1;
   end
   assign sleep_req = sleep_q;

   // wake-pending flag
   logic pend_clr;
   assign pend_clr = wr_en && sel_enter && wdata[PEND_BIT];
   dslp_w1c #(.N(1)) u_pend (
      .clk (clk),
      .rst_n (rst_n),
      .set (wake),
      .clr (pend_clr),
      .q (pend_q)
   );

   // reset-cause flags
   logic [N_RST-1:0] rst_clr, rst_flags_q;
   assign rst_clr = (wr_en && sel_status) ? wdata[ST_RST_LSB +: N_RST] : '0;
   dslp_w1c #(.N(N_RST)) u_rstflags (
      .clk (clk),
      .rst_n (rst_n),
      .set (rst_cause),
      .clr (rst_clr),
      .q (rst_flags_q)
   );

   // read mux
   always_comb begin
      rdata = '0;
      unique case (1'b1)
         sel_enter:  rdata[PEND_BIT] = pend_q;
         sel_policy: begin
            rdata[POL_DC]  = pol_q[POL_DC];
            rdata[POL_VDD] = pol_q[POL_VDD];
         end
         sel_status: begin
            rdata[ST_MODE] = mode_s;
            rdata[ST_DC]   = dc_s;
            rdata[ST_VDD]  = vdd_s;
            rdata[ST_RST_LSB +: N_RST] = rst_flags_q;
         end
         default: rdata = '0;
      endcase
   end

   logic unused_armed;
   assign unused_armed = armed;
endmodule

// File: rtl/dslp_entry_chk.sv
module dslp_entry_chk
   import dslp_pkg::*;
#(
   parameter int                ADDR_W    = 2,
   parameter int                DATA_W    = 32,
   parameter int                N_RST     = 3,
   parameter logic [DATA_W-1:0] ENTER_KEY = DATA_W'(KEY_ENTER_DEF)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              wake_evt,
   input logic [N_RST-1:0]  rst_cause,
   input logic              sleep_req,
   input logic              mode_s,
   input logic              dc_s,
   input logic              vdd_s,
   input logic [1:0]        pol,
   input logic              pend,
   input logic [N_RST-1:0]  flags
);
   AST_ENTRY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_req) |-> $past(wr_en && addr == ADDR_W'(REG_ENTER) && wdata == ENTER_KEY)); // R2
   AST_MODE_VETO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_req) |-> $past(mode_s)); // R4
   AST_PEND_VETO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_req) |-> !$past(pend)); // R5
   AST_DC_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_req) |-> $past(pol[POL_DC] || dc_s)); // R6
   AST_VDD_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_req) |-> $past(pol[POL_VDD] || vdd_s)); // R7
   AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req && wake_evt) |=> (!sleep_req && pend)); // R8
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_cause != '0) |=> ((flags & $past(rst_cause)) == $past(rst_cause))); // R10
endmodule

bind dslp_entry_ctrl dslp_entry_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .N_RST (N_RST),
   .ENTER_KEY (ENTER_KEY)
) u_chk (
   .clk (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .addr (addr),
   .wdata (wdata),
   .wake_evt (wake_evt),
   .rst_cause (rst_cause),
   .sleep_req (sleep_req),
   .mode_s (mode_s),
   .dc_s (dc_s),
   .vdd_s (vdd_s),
   .pol (pol_q),
   .pend (pend_q),
   .flags (rst_flags_q)
);

// File: tb/sim_dslp_entry_ctrl.sv
`timescale 1ns/1ps
module sim_dslp_entry_ctrl;
   localparam logic [31:0] KA = 32'hAA5555AA;
   localparam logic [31:0] KB = 32'h55AAAA55;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        mode_pin = 1'b1;
   logic        dcin_drop = 1'b1;
   logic        vdd_low = 1'b1;
   logic        wake_evt = 1'b0;
   logic [2:0]  rst_cause = '0;
   logic        sleep_req;

   dslp_entry_ctrl u0 (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr), .wdata (wdata),
      .rdata (rdata), .mode_pin (mode_pin), .dcin_drop (dcin_drop), .vdd_low (vdd_low),
      .wake_evt (wake_evt), .rst_cause (rst_cause), .sleep_req (sleep_req)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference model
   bit       m_req, m_pend, m_arm;
   bit [1:0] m_pol;
   bit [2:0] m_flg;
   bit       mq[$], dq[$], vq[$];
   bit       n_ent, n_wake, n_req, n_pend, n_arm;
   bit [1:0] n_pol;
   bit [2:0] n_flg;

   function automatic bit syn(ref bit q[$]);
      return (q.size() == 2) ? q[0] : 1'b0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_req = 0; m_pend = 0; m_arm = 0; m_pol = 0; m_flg = 0;
         mq.delete(); dq.delete(); vq.delete();
      end else begin
         n_ent = wr_en && addr == 1 && wdata == KB && m_arm && syn(mq) && !m_pend
                 && (m_pol[0] || syn(dq)) && (m_pol[1] || syn(vq));
         n_wake = m_req && (wake_evt || (!m_pol[0] && !syn(dq)) || (!m_pol[1] && !syn(vq)));
         n_req = n_wake ? 1'b0 : (n_ent ? 1'b1 : m_req);
         n_pend = n_wake ? 1'b1 : ((wr_en && addr == 1 && wdata[1]) ? 1'b0 : m_pend);
         n_arm = wr_en ? (addr == 0 && wdata == KA) : m_arm;
         n_pol = (wr_en && addr == 2) ? wdata[1:0] : m_pol;
         for (int i = 0; i < 3; i++)
            n_flg[i] = rst_cause[i] ? 1'b1 : ((wr_en && addr == 3 && wdata[4+i]) ? 1'b0 : m_flg[i]);
         m_req = n_req; m_pend = n_pend; m_arm = n_arm; m_pol = n_pol; m_flg = n_flg;
         mq.push_back(mode_pin); if (mq.size() > 2) void'(mq.pop_front());
         dq.push_back(dcin_drop); if (dq.size() > 2) void'(dq.pop_front());
         vq.push_back(vdd_low); if (vq.size() > 2) void'(vq.pop_front());
      end
   end

   function automatic logic [31:0] model_rd(input logic [1:0] a);
      logic [31:0] r = '0;
      case (a)
         2'd1: r[1] = m_pend;
         2'd2: r[1:0] = m_pol;
         2'd3: begin
            r[0] = syn(mq); r[1] = syn(dq); r[2] = syn(vq); r[6:4] = m_flg;
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks += 2;
         if (sleep_req !== m_req) begin
            errors++;
            $display("FAIL R2 model sleep_req actual %b expected %b at %0t", sleep_req, m_req, $time);
         end
         if (rdata !== model_rd(addr)) begin
            errors++;
            $display("FAIL R12 model rdata[%0d] actual %h expected %h at %0t", addr, rdata, model_rd(addr), $time);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic see_sleep(input logic exp, input string tag);
      @(negedge clk);
      chk(tag, {31'b0, sleep_req}, {31'b0, exp});
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] mask, input logic [31:0] exp, input string tag);
      addr = a;
      @(negedge clk);
      chk(tag, rdata & mask, exp);
   endtask

   task automatic keys();
      wr(0, KA);
      wr(1, KB);
   endtask

   task automatic pulse_wake();
      @(posedge clk); #1 wake_evt = 1;
      @(posedge clk); #1 wake_evt = 0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired, run hung");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      @(negedge clk);
      chk("R1 sleep_req after reset", {31'b0, sleep_req}, 32'd0);
      rd(1, 32'hFFFF_FFFF, 32'd0, "R1 pending clear after reset");
      rd(2, 32'hFFFF_FFFF, 32'd0, "R1 policy zero after reset");
      rd(3, 32'h70, 32'd0, "R1 reset flags zero after reset");
      idle(3);

      // R12 readback
      wr(2, 32'hFFFF_FFFC);
      rd(2, 32'hFFFF_FFFF, 32'd0, "R12 policy ignores upper bits");
      wr(2, 32'd3);
      rd(2, 32'hFFFF_FFFF, 32'd3, "R12 policy readback");
      wr(2, 32'd0);
      rd(0, 32'hFFFF_FFFF, 32'd0, "R12 pass register reads zero");

      // R2 good sequence, R8 wake
      keys();
      see_sleep(1, "R2 entry after key pair");
      pulse_wake();
      see_sleep(0, "R8 wake drops request");
      rd(1, 32'hFFFF_FFFF, 32'd2, "R8 wake sets pending");

      // R5 pending veto, then clear
      keys();
      see_sleep(0, "R5 pending vetoes entry");
      wr(1, 32'd2);
      rd(1, 32'hFFFF_FFFF, 32'd0, "R8 W1C clears pending");
      keys();
      see_sleep(1, "R5 entry once pending cleared");
      pulse_wake();
      see_sleep(0, "R8 second wake");
      // same-edge set and clear: set wins
      keys();
      wr(1, 32'd2);
      keys();
      see_sleep(1, "R8 re-entry");
      @(posedge clk); #1 wake_evt = 1; wr_en = 1; addr = 1; wdata = 32'd2;
      @(posedge clk); #1 wake_evt = 0; wr_en = 0;
      rd(1, 32'hFFFF_FFFF, 32'd2, "R8 set beats clear");
      wr(1, 32'd2);
      pulse_wake();
      rd(1, 32'hFFFF_FFFF, 32'd0, "R8 wake while awake ignored");

      // R3 broken sequences
      wr(0, KA); wr(2, 32'd0); wr(1, KB);
      see_sleep(0, "R3 intervening write cancels");
      wr(0, KA ^ 32'h1); wr(1, KB);
      see_sleep(0, "R3 wrong pass key");
      wr(0, KA); wr(1, KB ^ 32'h100);
      see_sleep(0, "R3 wrong enter key");
      wr(1, KB); wr(0, KA);
      see_sleep(0, "R3 reversed order");
      wr(2, 32'd0);
      wr(1, KB);
      see_sleep(0, "R3 enter key alone");
      rd(1, 32'hFFFF_FFFF, 32'd0, "R3 failed attempt leaves no pending");

      // R4 mode veto
      mode_pin = 0; idle(3);
      rd(3, 32'h1, 32'd0, "R4 mode status reads 0");
      keys();
      see_sleep(0, "R4 debug mode vetoes");
      mode_pin = 1; idle(3);
      rd(3, 32'h1, 32'd1, "R4 mode status reads 1");

      // R6 DC-in policy
      dcin_drop = 0; idle(3);
      keys();
      see_sleep(0, "R6 DC-in present vetoes at policy 0");
      wr(2, 32'd1);
      keys();
      see_sleep(1, "R6 policy 1 ignores DC-in");
      pulse_wake();
      wr(1, 32'd2);
      wr(2, 32'd0);
      dcin_drop = 1; idle(3);

      // R9 supply return wake
      keys();
      see_sleep(1, "R9 entered with DC-in dropped");
      dcin_drop = 0;
      idle(2);
      @(negedge clk);
      chk("R9 no early wake before sync", {31'b0, sleep_req}, 32'd1);
      idle(1);
      see_sleep(0, "R9 DC-in return wakes");
      rd(1, 32'hFFFF_FFFF, 32'd2, "R9 supply wake sets pending");
      wr(1, 32'd2);
      dcin_drop = 1; idle(3);

      // R7 VDD policy
      vdd_low = 0; idle(3);
      keys();
      see_sleep(0, "R7 VDD high vetoes at policy 0");
      wr(2, 32'd2);
      keys();
      see_sleep(1, "R7 policy 1 ignores VDD");
      pulse_wake();
      wr(1, 32'd2);
      wr(2, 32'd0);
      vdd_low = 1; idle(3);

      // R11 synchroniser latency
      addr = 3;
      @(posedge clk); #1 vdd_low = 0;
      @(negedge clk);
      @(negedge clk);
      chk("R11 one edge: still old", {31'b0, rdata[2]}, 32'd1);
      @(negedge clk);
      chk("R11 two edges: new value", {31'b0, rdata[2]}, 32'd0);
      vdd_low = 1; idle(3);

      // R10 reset flags
      @(posedge clk); #1 rst_cause = 3'b101;
      @(posedge clk); #1 rst_cause = 3'b000;
      rd(3, 32'h70, 32'h50, "R10 flags set by pulses");
      wr(3, 32'h10);
      rd(3, 32'h70, 32'h40, "R10 W1C clears external flag");
      @(posedge clk); #1 rst_cause = 3'b010; wr_en = 1; addr = 3; wdata = 32'h60;
      @(posedge clk); #1 rst_cause = 3'b000; wr_en = 0;
      rd(3, 32'h70, 32'h20, "R10 set beats clear, other cleared");
      wr(3, 32'h70);
      rd(3, 32'h70, 32'h00, "R10 all cleared");

      idle(4);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule